// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual address that did not hit any block translation by searching a hashed page table held in memory. The upper four address bits pick one of sixteen segment registers. The segment supplies a virtual segment identifier and two key bits. The walker then computes a group address from a table-base input. It fetches the eight two-word entries of that group one word at a time over a valid/ready memory port. If no entry matches, it repeats the search in the secondary group.

A successful walk returns the real page number and the read and write permissions for the access. When the referenced or changed bits of the matching entry need to change, the walker writes the updated second word back in place first. A failed walk returns a fault code, plus a flag that marks the faulting access as a store. Segments marked direct-store, and instruction fetches from no-execute segments, fault at once without any memory traffic. Segment registers are loaded through a small configuration write port.

Top module: `hpt_walker`

## Requirements
- R1: A request whose segment register has bit 31 set ends with fault code 4 (direct-store) on the cycle after acceptance, and the walker issues no memory access for it.
- R2: An instruction fetch (req_fetch=1) whose segment register has bit 28 set ends with fault code 3 (no-execute) and issues no memory access. A load or store to the same segment is walked normally.
- R3: With VSID = segment bits 23:0 and page index P = address bits 27:12, the primary hash H1 is ((VSID xor P) and 0x7FFFF) << 6. The secondary hash is (not H1) and 0x01FFFFC0. The group address is (base and 0xFFFF0000) or (hash and ((base[8:0] << 16) or 0xFFC0)). Entry i is read as word 0 at group+8i and then word 1 at group+8i+4, for i = 0 to 7 in order.
- R4: An entry matches only when word 0 bit 31 is set, word 0 bit 6 equals the pass (0 primary, 1 secondary), and (word 0 and 0x7FFFFFBF) equals (VSID << 7) or (P >> 10).
- R5: The secondary group is read only when no entry of the primary group matches. When neither group matches, the result is fault code 1 after 32 reads.
- R6: When two matching entries differ in word 1 under mask 0xFFFFF07B, the result is fault code 5. Matches that differ only outside that mask are accepted, and the first one is used.
- R7: The key is segment bit 29 for user accesses and segment bit 30 for supervisor accesses. With key 0, read is always granted and write is granted unless PP (word 1 bits 1:0) is 3. With key 1, PP=0 grants nothing, PP=2 grants read and write, and PP=1 or 3 grants read only.
- R8: An access that the decoded permission does not allow ends with fault code 2 and no memory write. Every fault result reports both permissions as 0.
- R9: On success, the real page number is word 1 bits 31:12. The walker sets bit 8 (referenced), and on a store also bit 7 (changed). If this alters word 1, the new value is written once to that entry's word-1 address before the result. Otherwise nothing is written.
- R10: On a successful load or fetch whose entry has the changed bit clear, write permission is reported as 0 even when the key and PP would allow it.
- R11: res_store_fault is 1 exactly when a faulting request was a store. A successful result reports fault code 0 with the flag clear.
- R12: After reset, req_ready is 1 and no memory request is raised. A memory request holds its valid, address and write flag until accepted. No new request is issued while a read response is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seg_we | input | 1 | Segment register write enable |
| cfg_seg_idx | input | 4 | Segment register index to write |
| cfg_seg_data | input | 32 | Segment register write value |
| tbl_base | input | 32 | Page table base and hash mask extension |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user state |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write (no response follows) |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 3 | 0 ok, 1 no match, 2 protection, 3 no-execute, 4 direct-store, 5 conflicting matches |
| res_store_fault | output | 1 | Faulting access was a store |
| res_rpn | output | 20 | Real page number |
| res_read_ok | output | 1 | Read permitted |
| res_write_ok | output | 1 | Write permitted |

## Verification
Several properties are checked on every cycle. A memory request holds steady while stalled, and no request is issued while a read is owed. Every write-back sets the referenced bit and targets a word-1 address. Direct-store requests resolve on the next cycle. Faults never carry permissions, and write permission always comes with read permission. The hash arithmetic, match rule, pass ordering, conflict detection, key-by-PP permission table and write-back values are shown only by the bench's scenarios. The bench sweeps every PP, key, access type and changed-bit combination, then runs secondary-group, conflict and invalid-entry walks against a memory model that counts reads and records writes.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] MATCH_MASK = 32'h7FFF_FFBF;
  localparam logic [31:0] AGREE_MASK = 32'hFFFF_F07B;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_NOMATCH  = 3'd1,
    FLT_PROT     = 3'd2,
    FLT_NOEXEC   = 3'd3,
    FLT_DSTORE   = 3'd4,
    FLT_CONFLICT = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_EVAL, ST_WB_REQ, ST_DONE
  } walk_state_e;
endpackage

// File: rtl/hpt_seg_file.sv
module hpt_seg_file #(
  parameter int SEG_COUNT = 16,
  localparam int IDX_W = $clog2(SEG_COUNT)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [hpt_pkg::WORD_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [hpt_pkg::WORD_W-1:0]    rd_data
);
  logic [hpt_pkg::WORD_W-1:0] regs [SEG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEG_COUNT; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash (
  input  logic [23:0] vsid,
  input  logic [15:0] pidx,
  input  logic [31:0] base,
  input  logic        secondary,
  output logic [31:0] group_addr
);
  logic [18:0] h19;
  logic [31:0] h_pri, h_sec, h_sel, h_mask;

  always_comb begin
    h19    = vsid[18:0] ^ {3'b000, pidx};
    h_pri  = {7'b0, h19, 6'b0};
    h_sec  = ~h_pri & 32'h01FF_FFC0;
    h_sel  = secondary ? h_sec : h_pri;
    h_mask = {7'b0, base[8:0], 16'hFFC0};
    group_addr = {base[31:16], 16'h0000} | (h_sel & h_mask);
  end
endmodule

// File: rtl/hpt_perm.sv
module hpt_perm (
  input  logic [1:0] pp,
  input  logic       key,
  output logic       can_read,
  output logic       can_write
);
  always_comb begin
    if (!key) begin
      can_read  = 1'b1;
      can_write = (pp != 2'd3);
    end else begin
      unique case (pp)
        2'd0:    begin can_read = 1'b0; can_write = 1'b0; end
        2'd2:    begin can_read = 1'b1; can_write = 1'b1; end
        default: begin can_read = 1'b1; can_write = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int SEG_COUNT     = 16,
  parameter int GROUP_ENTRIES = 8,
  localparam int SEG_IDX_W    = $clog2(SEG_COUNT),
  localparam int ENT_IDX_W    = $clog2(GROUP_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_seg_we,
  input  logic [SEG_IDX_W-1:0] cfg_seg_idx,
  input  logic [31:0]          cfg_seg_data,
  input  logic [31:0]          tbl_base,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_vaddr,
  input  logic                 req_store,
  input  logic                 req_fetch,
  input  logic                 req_user,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_write,
  output logic [31:0]          mem_req_addr,
  output logic [31:0]          mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data,
  output logic                 res_valid,
  output logic [2:0]           res_fault,
  output logic                 res_store_fault,
  output logic [19:0]          res_rpn,
  output logic                 res_read_ok,
  output logic                 res_write_ok
);
  import hpt_pkg::*;

  localparam logic [ENT_IDX_W-1:0] LAST_ENT = ENT_IDX_W'(GROUP_ENTRIES - 1);

  walk_state_e state;
  logic [31:0] seg_q;
  logic        st_r, key_r, pass_r, word_r, found_r;
  logic [23:0] vsid_r;
  logic [15:0] pidx_r;
  logic [31:0] base_r, w0_r, keep_r, wb_r;
  logic [ENT_IDX_W-1:0] idx_r, hit_r;
  logic [2:0]  fault_q;
  logic        sflag_q, rd_q, wr_q;
  logic [19:0] rpn_q;

  hpt_seg_file #(.SEG_COUNT(SEG_COUNT)) u_seg (
    .clk(clk), .rst(rst), .wr_en(cfg_seg_we), .wr_idx(cfg_seg_idx),
    .wr_data(cfg_seg_data), .rd_idx(req_vaddr[31 -: SEG_IDX_W]), .rd_data(seg_q)
  );

  logic [31:0] group_addr;
  hpt_hash u_hash (
    .vsid(vsid_r), .pidx(pidx_r), .base(base_r), .secondary(pass_r),
    .group_addr(group_addr)
  );

  logic p_rd, p_wr;
  hpt_perm u_perm (.pp(keep_r[1:0]), .key(key_r), .can_read(p_rd), .can_write(p_wr));

  logic [31:0] ptem, upd;
  logic        hit_now, disagree;
  logic [ENT_IDX_W-1:0] a_idx;
  logic        a_word;

  always_comb begin
    ptem     = {1'b0, vsid_r, 1'b0, pidx_r[15:10]};
    hit_now  = w0_r[31] && (w0_r[6] == pass_r) && ((w0_r & MATCH_MASK) == ptem);
    disagree = ((keep_r ^ mem_rsp_data) & AGREE_MASK) != 32'h0;
    upd      = keep_r | 32'h0000_0100 | (st_r ? 32'h0000_0080 : 32'h0);
    a_idx    = (state == ST_WB_REQ) ? hit_r : idx_r;
    a_word   = (state == ST_WB_REQ) ? 1'b1 : word_r;
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ);
  assign mem_req_write = (state == ST_WB_REQ);
  assign mem_req_addr  = group_addr + {{(32-ENT_IDX_W-3){1'b0}}, a_idx, a_word, 2'b00};
  assign mem_req_wdata = wb_r;
  assign res_valid       = (state == ST_DONE);
  assign res_fault       = fault_q;
  assign res_store_fault = sflag_q;
  assign res_rpn         = rpn_q;
  assign res_read_ok     = rd_q;
  assign res_write_ok    = wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      {st_r, key_r, pass_r, word_r, found_r} <= '0;
      vsid_r <= '0; pidx_r <= '0; base_r <= '0;
      w0_r <= '0; keep_r <= '0; wb_r <= '0;
      idx_r <= '0; hit_r <= '0;
      fault_q <= FLT_NONE; sflag_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0;
      rpn_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          st_r   <= req_store;
          key_r  <= req_user ? seg_q[29] : seg_q[30];
          vsid_r <= seg_q[23:0];
          pidx_r <= req_vaddr[27:12];
          base_r <= tbl_base;
          rd_q <= 1'b0; wr_q <= 1'b0; rpn_q <= '0;
          if (seg_q[31] || (req_fetch && seg_q[28])) begin
            fault_q <= seg_q[31] ? FLT_DSTORE : FLT_NOEXEC;
            sflag_q <= req_store;
            state   <= ST_DONE;
          end else begin
            pass_r <= 1'b0; idx_r <= '0; word_r <= 1'b0; found_r <= 1'b0;
            state  <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (!word_r) begin
            w0_r   <= mem_rsp_data;
            word_r <= 1'b1;
            state  <= ST_RD_REQ;
          end else begin
            word_r <= 1'b0;
            if (hit_now && found_r && disagree) begin
              fault_q <= FLT_CONFLICT; sflag_q <= st_r; state <= ST_DONE;
            end else begin
              if (hit_now && !found_r) begin
                found_r <= 1'b1; keep_r <= mem_rsp_data; hit_r <= idx_r;
              end
              if (idx_r == LAST_ENT) state <= ST_EVAL;
              else begin
                idx_r <= idx_r + 1'b1;
                state <= ST_RD_REQ;
              end
            end
          end
        end
        ST_EVAL: begin
          if (!found_r) begin
            if (!pass_r) begin
              pass_r <= 1'b1; idx_r <= '0; state <= ST_RD_REQ;
            end else begin
              fault_q <= FLT_NOMATCH; sflag_q <= st_r; state <= ST_DONE;
            end
          end else if (!(st_r ? p_wr : p_rd)) begin
            fault_q <= FLT_PROT; sflag_q <= st_r; state <= ST_DONE;
          end else begin
            fault_q <= FLT_NONE; sflag_q <= 1'b0;
            rpn_q   <= keep_r[31:12];
            rd_q    <= p_rd;
            wr_q    <= p_wr && (st_r || keep_r[7]);
            wb_r    <= upd;
            state   <= (upd != keep_r) ? ST_WB_REQ : ST_DONE;
          end
        end
        ST_WB_REQ: if (mem_req_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Read-response tracker used only by the checks below.
  logic rd_owed;
  always_ff @(posedge clk) begin
    if (rst) rd_owed <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_owed <= 1'b1;
    else if (mem_rsp_valid) rd_owed <= 1'b0;
  end

  a_r12_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    rd_owed |-> !mem_req_valid);
  a_r1_dstore_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && seg_q[31]) |=> (res_valid && res_fault == FLT_DSTORE));
  a_r9_writeback_refbit: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[8] && mem_req_addr[2]));
  a_r8_fault_no_perm: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault != FLT_NONE) |-> (!res_read_ok && !res_write_ok));
  a_r10_write_needs_read: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_write_ok) |-> res_read_ok);
  a_r11_store_flag_on_fault: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_store_fault) |-> (res_fault != FLT_NONE));
endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cfg_seg_we = 0;
  logic [3:0]  cfg_seg_idx = 0;
  logic [31:0] cfg_seg_data = 0;
  logic [31:0] tbl_base = 32'h0001_0000;
  logic        req_valid = 0, req_store = 0, req_fetch = 0, req_user = 0;
  logic [31:0] req_vaddr = 0;
  logic        req_ready;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        res_valid, res_store_fault, res_read_ok, res_write_ok;
  logic [2:0]  res_fault;
  logic [19:0] res_rpn;

  hpt_walker u_dut (
    .clk(clk), .rst(rst), .cfg_seg_we(cfg_seg_we), .cfg_seg_idx(cfg_seg_idx),
    .cfg_seg_data(cfg_seg_data), .tbl_base(tbl_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_store(req_store),
    .req_fetch(req_fetch), .req_user(req_user), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_store_fault(res_store_fault),
    .res_rpn(res_rpn), .res_read_ok(res_read_ok), .res_write_ok(res_write_ok)
  );

  int checks = 0, failures = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Memory model: a few planted words, the rest read as zero.
  logic [31:0] pa [8];
  logic [31:0] pd [8];
  int nplant = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_wa = 0, last_wd = 0;
  int cyc = 0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < nplant; i++) if (pa[i] == a) return pd[i];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_cnt  <= wr_cnt + 1;
        last_wa <= mem_req_addr;
        last_wd <= mem_req_wdata;
        for (int i = 0; i < nplant; i++) if (pa[i] == mem_req_addr) pd[i] <= mem_req_wdata;
      end else begin
        rd_cnt        <= rd_cnt + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= lookup(mem_req_addr);
      end
    end
  end

  // Handshake monitor (R12)
  int hs_err = 0;
  logic prev_stall = 0;
  logic [31:0] prev_addr = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hs_err++;
      if (mem_rsp_valid && mem_req_valid) hs_err++;
    end
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
  end

  task automatic plant(input logic [31:0] a, input logic [31:0] d);
    pa[nplant] = a; pd[nplant] = d; nplant++;
  endtask

  function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [15:0] pg,
                                      input logic [31:0] base, input bit sec);
    logic [31:0] h, m;
    h = ((32'(vsid) ^ 32'(pg)) & 32'h7FFFF) << 6;
    if (sec) h = ~h & 32'h01FF_FFC0;
    m = ((base & 32'h1FF) << 16) | 32'hFFC0;
    return (base & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] w0(input logic [23:0] vsid, input logic [15:0] pg, input bit h);
    return 32'h8000_0000 | (32'(h) << 6) | (32'(vsid) << 7) | (32'(pg) >> 10);
  endfunction

  task automatic seg_write(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk); cfg_seg_we = 1; cfg_seg_idx = i; cfg_seg_data = d;
    @(negedge clk); cfg_seg_we = 0;
  endtask

  int rds, wrs;
  task automatic run(input logic [31:0] va, input bit st, input bit fe, input bit us);
    int r0, w0c;
    r0 = rd_cnt; w0c = wr_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_store = st; req_fetch = fe; req_user = us; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!res_valid) @(negedge clk);
    rds = rd_cnt - r0; wrs = wr_cnt - w0c;
  endtask

  localparam logic [23:0] VS = 24'h000123;
  localparam logic [31:0] VA = 32'h1ABC_D000;
  localparam logic [15:0] PG = 16'hABCD;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] g0, g1, w1v, exp_wd;
    bit key, prd, pwr, ok;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R12 reset ready", 32'(req_ready), 1);
    check("R12 reset no request", 32'(mem_req_valid), 0);
    check("R12 reset no result", 32'(res_valid), 0);
    seg_write(4'd1, 32'h2000_0123);
    seg_write(4'd2, 32'h8000_0000);
    seg_write(4'd3, 32'h1000_0456);

    // R1 direct-store
    run(32'h2000_0000, 1, 0, 0);
    check("R1 dstore code", 32'(res_fault), 4);
    check("R1 dstore no reads", rds, 0);
    check("R11 dstore store flag", 32'(res_store_fault), 1);
    check("R8 dstore no perm", {res_read_ok, res_write_ok}, 0);

    // R2 no-execute fetch, then a store to same segment walks (R5 no match)
    run(32'h3000_1000, 0, 1, 0);
    check("R2 noexec code", 32'(res_fault), 3);
    check("R2 noexec no reads", rds, 0);
    check("R11 load fault flag clear", 32'(res_store_fault), 0);
    run(32'h3000_1000, 1, 0, 0);
    check("R2 store walks, R5 nomatch code", 32'(res_fault), 1);
    check("R5 both groups read", rds, 32);
    check("R11 store nomatch flag", 32'(res_store_fault), 1);

    // Sweep R7/R8/R9/R10 over PP, key, access, changed bit
    g0 = grp(VS, PG, tbl_base, 0);
    for (int pp = 0; pp < 4; pp++)
      for (int us = 0; us < 2; us++)
        for (int st = 0; st < 2; st++)
          for (int cb = 0; cb < 2; cb++) begin
            nplant = 0;
            w1v = 32'h1234_5000 | (32'(cb) << 7) | 32'(pp);
            plant(g0 + 24, w0(VS, PG, 0));
            plant(g0 + 28, w1v);
            run(VA, st[0], 0, us[0]);
            key = us[0];
            if (!key) begin prd = 1; pwr = (pp != 3); end
            else begin prd = (pp != 0); pwr = (pp == 2); end
            ok = st[0] ? pwr : prd;
            check("R3 R4 primary reads", rds, 16);
            if (ok) begin
              exp_wd = w1v | 32'h100 | (st[0] ? 32'h80 : 0);
              check("R7 ok code", 32'(res_fault), 0);
              check("R9 rpn", 32'(res_rpn), 32'h12345);
              check("R7 read perm", 32'(res_read_ok), 32'(prd));
              check("R10 write perm", 32'(res_write_ok), 32'(pwr && (st[0] || cb[0])));
              check("R9 one write", wrs, 1);
              check("R9 write addr", last_wa, g0 + 28);
              check("R9 write data", last_wd, exp_wd);
              check("R11 ok flag clear", 32'(res_store_fault), 0);
            end else begin
              check("R8 prot code", 32'(res_fault), 2);
              check("R8 no write", wrs, 0);
              check("R8 no perm", {res_read_ok, res_write_ok}, 0);
              check("R11 prot flag", 32'(res_store_fault), 32'(st));
            end
          end

    // R9: referenced and changed already set, load -> no write
    nplant = 0;
    plant(g0 + 0, w0(VS, PG, 0));
    plant(g0 + 4, 32'h0ABCD_180 | 32'h2);
    run(VA, 0, 0, 0);
    check("R9 no-change code", 32'(res_fault), 0);
    check("R9 no-change no write", wrs, 0);
    check("R10 changed set keeps write", 32'(res_write_ok), 1);

    // R5 secondary with a wrong-pass distractor in primary (R4)
    g1 = grp(VS, PG, tbl_base, 1);
    nplant = 0;
    plant(g0 + 0, w0(VS, PG, 1));
    plant(g0 + 4, 32'h0DEAD_002);
    plant(g1 + 56, w0(VS, PG, 1));
    plant(g1 + 60, 32'h0BEEF_182);
    run(VA, 0, 0, 0);
    check("R5 secondary code", 32'(res_fault), 0);
    check("R5 secondary reads", rds, 32);
    check("R4 secondary rpn", 32'(res_rpn), 32'h0BEEF);

    // R6 conflict
    nplant = 0;
    plant(g0 + 8, w0(VS, PG, 0));  plant(g0 + 12, 32'h1111_1002);
    plant(g0 + 40, w0(VS, PG, 0)); plant(g0 + 44, 32'h2222_2002);
    run(VA, 0, 0, 0);
    check("R6 conflict code", 32'(res_fault), 5);
    check("R6 conflict no write", wrs, 0);

    // R6 agreeing matches: first used
    nplant = 0;
    plant(g0 + 8, w0(VS, PG, 0));  plant(g0 + 12, 32'h3333_3002);
    plant(g0 + 40, w0(VS, PG, 0)); plant(g0 + 44, 32'h3333_3182);
    run(VA, 1, 0, 0);
    check("R6 agree code", 32'(res_fault), 0);
    check("R6 first entry written", last_wa, g0 + 12);
    check("R9 store write data", last_wd, 32'h3333_3182);

    // R4 invalid entry ignored
    nplant = 0;
    plant(g0 + 16, w0(VS, PG, 0) & 32'h7FFF_FFFF); plant(g0 + 20, 32'h4444_4002);
    run(VA, 0, 0, 0);
    check("R4 invalid ignored", 32'(res_fault), 1);

    // R3 hash mask extension from base low bits
    tbl_base = 32'h00F0_0003;
    g0 = grp(VS, PG, tbl_base, 0);
    nplant = 0;
    plant(g0 + 32, w0(VS, PG, 0)); plant(g0 + 36, 32'h5555_5102);
    run(VA, 0, 0, 0);
    check("R3 extended mask hit", 32'(res_fault), 0);
    check("R3 extended rpn", 32'(res_rpn), 32'h55555);

    check("R12 handshake monitor", hs_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule